// File: doc/BRIEF.md
# Mirrored Channel Read Steering

This block sits in front of a pair of memory channels and decides, for every access request, which of the two channels receives it. It has three operating modes, chosen by configuration inputs. In single-channel mode every access goes to a configured home channel. In mirrored mode writes are copied to both channels, and reads are spread across them by a one-bit alternation pointer. In lockstep mode both channels serve every access as one wide channel. Mirrored and lockstep modes take effect only while the channel mapping is marked valid. Lockstep takes precedence when both enables are set.

While mirrored mode is active, an uncorrectable error reported against either channel marks the pair as degraded. A sticky redundancy-lost flag is set and the failing channel is recorded. From then on every access goes only to the surviving channel. Only a software channel-reset pulse clears the flag. The steering decision is registered, so the channel request strobes appear one clock after the request.

Top module: `mirror_steer`

## Requirements
- R1: After reset `ch_vld` is 2'b00, `redun_lost` is 0 and `failed_ch` is 0. The alternation pointer starts at channel 0, so the first read in active mirrored mode goes to channel 0 (`ch_vld` = 2'b01).
- R2: Mirrored mode is active when `cfg_mirror_en`=1, `cfg_map_valid`=1 and `cfg_lockstep_en`=0. In this mode, while redundancy is intact, successive reads alternate between channel 0 (`ch_vld` bit 0) and channel 1 (`ch_vld` bit 1).
- R3: With `cfg_map_valid`=0, the mirror enable has no effect. Every access goes to the home channel, and no read changes the pointer.
- R4: In active mirrored mode with redundancy intact, a write is sent to both channels (`ch_vld` = 2'b11).
- R5: An uncorrectable error report (`ue_valid`=1) during active mirrored mode sets `redun_lost` at the next clock edge and records `ue_ch` in `failed_ch`. If redundancy is already lost, a report changes nothing.
- R6: `redun_lost` and `failed_ch` hold until a `sw_ch_reset` pulse, which clears both at the next edge. A clear pulse wins over an error report in the same cycle.
- R7: After redundancy is lost in mirrored mode, every read and write goes only to the channel other than `failed_ch`. The pointer does not move.
- R8: In lockstep mode (`cfg_lockstep_en`=1 and `cfg_map_valid`=1), every access goes to both channels, whatever the mirror enable or the loss flag.
- R9: When mirrored mode is not active, accesses go to channel `cfg_home_ch` (0 gives 2'b01, 1 gives 2'b10). The pointer holds its value, so alternation resumes where it stopped. The pointer advances only on reads that are steered by alternation.
- R10: `ch_vld`, `out_write` and `out_tag` reflect the request presented one clock earlier. A cycle with `req_valid`=0 gives `ch_vld` = 2'b00.
- R11: Error reports received while mirrored mode is not active are ignored, and `redun_lost` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mirror_en | input | 1 | Mirrored mode enable |
| cfg_lockstep_en | input | 1 | Lockstep mode enable |
| cfg_map_valid | input | 1 | Channel mapping has been configured |
| cfg_home_ch | input | 1 | Channel used when no paired mode is active |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request identifier carried to the channels |
| ue_valid | input | 1 | Uncorrectable error report |
| ue_ch | input | 1 | Channel that reported the error |
| sw_ch_reset | input | 1 | Software channel reset, clears the loss status |
| ch_vld | output | 2 | Per-channel request strobe, bit n for channel n |
| out_write | output | 1 | Registered write flag |
| out_tag | output | TAG_W | Registered request identifier |
| redun_lost | output | 1 | Sticky redundancy-lost status |
| failed_ch | output | 1 | Channel recorded as failed |

## Verification
A wrong pointer value shows on the very next mirrored read, which lands on the wrong channel. A pointer that stops toggling shows within two reads as a repeated channel. A corrupted loss flag or failed-channel record appears on `redun_lost`/`failed_ch` one clock after the event. It also shows on the next access, which goes to both channels or to the failed one instead of the survivor. A mode decode fault shows on the first access after a configuration change, as a strobe pattern of the wrong width or on the wrong channel.

// File: rtl/mirror_steer_pkg.sv
package mirror_steer_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_MIRROR   = 2'd1,
    MODE_LOCKSTEP = 2'd2
  } steer_mode_e;

  // one-hot strobe for a single channel index
  function automatic logic [NCH-1:0] ch_bit(input logic ch);
    logic [NCH-1:0] m;
    m = '0;
    m[ch] = 1'b1;
    return m;
  endfunction

  // channel strobe pattern for one request
  function automatic logic [NCH-1:0] route_mask(
    input logic        vld,
    input logic        wr,
    input steer_mode_e mode,
    input logic        lost,
    input logic        failed,
    input logic        ptr,
    input logic        home
  );
    logic [NCH-1:0] m;
    m = '0;
    if (vld) begin
      unique case (mode)
        MODE_LOCKSTEP: m = '1;
        MODE_MIRROR: begin
          if (lost)    m = ch_bit(~failed);
          else if (wr) m = '1;
          else         m = ch_bit(ptr);
        end
        default:       m = ch_bit(home);
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/mirror_mode_dec.sv
module mirror_mode_dec
  import mirror_steer_pkg::*;
(
  input  logic        mirror_en,
  input  logic        lockstep_en,
  input  logic        map_valid,
  output steer_mode_e mode,
  output logic        mirror_act,
  output logic        lock_act
);
  always_comb begin
    mode = MODE_SINGLE;
    if (map_valid && lockstep_en)    mode = MODE_LOCKSTEP;
    else if (map_valid && mirror_en) mode = MODE_MIRROR;
  end

  assign mirror_act = (mode == MODE_MIRROR);
  assign lock_act   = (mode == MODE_LOCKSTEP);
endmodule

// File: rtl/mirror_alt_ptr.sv
module mirror_alt_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= 1'b0;
    else if (adv) ptr_q <= ~ptr_q;
  end
endmodule

// File: rtl/mirror_health.sv
module mirror_health (
  input  logic clk,
  input  logic rst_n,
  input  logic mirror_act,
  input  logic ue_valid,
  input  logic ue_ch,
  input  logic sw_clr,
  output logic lost_q,
  output logic failed_q,
  output logic set_evt
);
  // first failure in intact mirrored mode is latched; clear has priority
  assign set_evt = mirror_act && ue_valid && !lost_q && !sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q   <= 1'b0;
      failed_q <= 1'b0;
    end else if (sw_clr) begin
      lost_q   <= 1'b0;
      failed_q <= 1'b0;
    end else if (set_evt) begin
      lost_q   <= 1'b1;
      failed_q <= ue_ch;
    end
  end
endmodule

// File: rtl/mirror_route.sv
module mirror_route #(
  parameter int NCH   = 2,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   mask,
  input  logic             wr,
  input  logic [TAG_W-1:0] tag,
  output logic [NCH-1:0]   ch_vld,
  output logic             out_write,
  output logic [TAG_W-1:0] out_tag
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_vld[c] <= 1'b0;
      else        ch_vld[c] <= mask[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write <= 1'b0;
      out_tag   <= '0;
    end else if (|mask) begin
      out_write <= wr;
      out_tag   <= tag;
    end
  end
endmodule

// File: rtl/mirror_steer.sv
module mirror_steer
  import mirror_steer_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mirror_en,
  input  logic             cfg_lockstep_en,
  input  logic             cfg_map_valid,
  input  logic             cfg_home_ch,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             ue_valid,
  input  logic             ue_ch,
  input  logic             sw_ch_reset,
  output logic [NCH-1:0]   ch_vld,
  output logic             out_write,
  output logic [TAG_W-1:0] out_tag,
  output logic             redun_lost,
  output logic             failed_ch
);
  steer_mode_e    mode;
  logic           mirror_act;
  logic           lock_act;
  logic           ptr_q;
  logic           alt_adv;
  logic           lost_q;
  logic           failed_q;
  logic           loss_set;
  logic [NCH-1:0] route;

  mirror_mode_dec u_dec (
    .mirror_en  (cfg_mirror_en),
    .lockstep_en(cfg_lockstep_en),
    .map_valid  (cfg_map_valid),
    .mode       (mode),
    .mirror_act (mirror_act),
    .lock_act   (lock_act)
  );

  // pointer moves only for reads steered by alternation
  assign alt_adv = req_valid && !req_write && mirror_act && !lost_q;

  mirror_alt_ptr u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (alt_adv),
    .ptr_q(ptr_q)
  );

  mirror_health u_health (
    .clk       (clk),
    .rst_n     (rst_n),
    .mirror_act(mirror_act),
    .ue_valid  (ue_valid),
    .ue_ch     (ue_ch),
    .sw_clr    (sw_ch_reset),
    .lost_q    (lost_q),
    .failed_q  (failed_q),
    .set_evt   (loss_set)
  );

  assign route = route_mask(req_valid, req_write, mode, lost_q, failed_q,
                            ptr_q, cfg_home_ch);

  mirror_route #(.NCH(NCH), .TAG_W(TAG_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask     (route),
    .wr       (req_write),
    .tag      (req_tag),
    .ch_vld   (ch_vld),
    .out_write(out_write),
    .out_tag  (out_tag)
  );

  assign redun_lost = lost_q;
  assign failed_ch  = failed_q;
endmodule

// File: rtl/mirror_steer_chk.sv
module mirror_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic       ue_valid,
  input logic       sw_ch_reset,
  input logic       mirror_act,
  input logic       lock_act,
  input logic       alt_adv,
  input logic       ptr_q,
  input logic [1:0] ch_vld,
  input logic       redun_lost,
  input logic       failed_ch
);
  // R10: an idle cycle produces no channel strobe
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ch_vld == 2'b00);

  // R2: a read steered by alternation flips the pointer
  p_alt_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alt_adv |=> ptr_q != $past(ptr_q));

  // R9: the pointer holds when no alternated read is accepted
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_adv |=> $stable(ptr_q));

  // R5: an error in intact mirrored mode raises the loss flag
  p_loss_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_act && ue_valid && !sw_ch_reset) |=> redun_lost);

  // R6: the loss flag and the failed channel are sticky without a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redun_lost && !sw_ch_reset) |=> (redun_lost && $stable(failed_ch)));

  // R6: a clear pulse wins
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ch_reset |=> !redun_lost);

  // R7: after loss, a mirrored access goes to the surviving channel only
  p_survivor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mirror_act && redun_lost) |=> ch_vld == (failed_ch ? 2'b01 : 2'b10));

  // R8: lockstep drives both channels
  p_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_act) |=> ch_vld == 2'b11);

  // R11: reports outside mirrored mode leave an intact pair intact
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mirror_act && !redun_lost) |=> !redun_lost);

  // R4: an intact mirrored write goes to both channels
  p_write_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && mirror_act && !redun_lost) |=> ch_vld == 2'b11);
endmodule

bind mirror_steer mirror_steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .ue_valid   (ue_valid),
  .sw_ch_reset(sw_ch_reset),
  .mirror_act (mirror_act),
  .lock_act   (lock_act),
  .alt_adv    (alt_adv),
  .ptr_q      (ptr_q),
  .ch_vld     (ch_vld),
  .redun_lost (redun_lost),
  .failed_ch  (failed_ch)
);

// File: tb/mirror_steer_tb_top.sv
`timescale 1ns/1ps
module mirror_steer_tb_top;
  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_mirror_en = 1'b0, cfg_lockstep_en = 1'b0;
  logic             cfg_map_valid = 1'b0, cfg_home_ch = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             ue_valid = 1'b0, ue_ch = 1'b0, sw_ch_reset = 1'b0;
  logic [1:0]       ch_vld;
  logic             out_write;
  logic [TAG_W-1:0] out_tag;
  logic             redun_lost, failed_ch;

  always #2 clk = ~clk;  // 250 MHz

  mirror_steer #(.TAG_W(TAG_W)) dut_i (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [1:0]       strobe;
    logic             wr;
    logic [TAG_W-1:0] tag;
    logic             lost;
    logic             failed;
  } exp_t;

  exp_t  q_exp[$];
  string q_req[$];

  // bench-side configuration and reference state
  bit b_mir = 0, b_lock = 0, b_map = 0, b_home = 0;
  bit m_ptr = 0, m_lost = 0, m_failed = 0;

  task automatic set_cfg(input bit mir, input bit lock, input bit map, input bit home);
    b_mir = mir; b_lock = lock; b_map = map; b_home = home;
  endtask

  task automatic cyc(input bit v, input bit w, input logic [TAG_W-1:0] t,
                     input bit ue, input bit uec, input bit clr, input string rq);
    exp_t e;
    bit   paired_lock, paired_mir;
    @(negedge clk);
    cfg_mirror_en = b_mir; cfg_lockstep_en = b_lock;
    cfg_map_valid = b_map; cfg_home_ch = b_home;
    req_valid = v; req_write = w; req_tag = t;
    ue_valid = ue; ue_ch = uec; sw_ch_reset = clr;
    paired_lock = b_map && b_lock;
    paired_mir  = b_map && b_mir && !b_lock;
    e.strobe = 2'b00;
    if (v) begin
      if (paired_lock)      e.strobe = 2'b11;
      else if (paired_mir) begin
        if (m_lost)         e.strobe = m_failed ? 2'b01 : 2'b10;
        else if (w)         e.strobe = 2'b11;
        else                e.strobe = m_ptr ? 2'b10 : 2'b01;
      end else              e.strobe = b_home ? 2'b10 : 2'b01;
    end
    if (v && !w && paired_mir && !m_lost) m_ptr = !m_ptr;
    if (clr) begin
      m_lost = 0; m_failed = 0;
    end else if (ue && paired_mir && !m_lost) begin
      m_lost = 1; m_failed = uec;
    end
    e.wr = w; e.tag = t; e.lost = m_lost; e.failed = m_failed;
    q_exp.push_back(e);
    q_req.push_back(rq);
  endtask

  task automatic rd(input logic [TAG_W-1:0] t, input string rq);
    cyc(1, 0, t, 0, 0, 0, rq);
  endtask

  task automatic wrt(input logic [TAG_W-1:0] t, input string rq);
    cyc(1, 1, t, 0, 0, 0, rq);
  endtask

  task automatic idle(input string rq);
    cyc(0, 0, 0, 0, 0, 0, rq);
  endtask

  // monitor: compare one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      exp_t  e;
      string rq;
      bit    bad;
      e  = q_exp.pop_front();
      rq = q_req.pop_front();
      n_vec++;
      bad = (ch_vld !== e.strobe) || (redun_lost !== e.lost) || (failed_ch !== e.failed);
      if (e.strobe != 2'b00 && (out_write !== e.wr || out_tag !== e.tag)) bad = 1'b1;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: got strobe=%b wr=%b tag=%h lost=%b failed=%b, expected strobe=%b wr=%b tag=%h lost=%b failed=%b",
                 rq, ch_vld, out_write, out_tag, redun_lost, failed_ch,
                 e.strobe, e.wr, e.tag, e.lost, e.failed);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (ch_vld !== 2'b00 || redun_lost !== 1'b0 || failed_ch !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got strobe=%b lost=%b failed=%b, expected 00 0 0",
               ch_vld, redun_lost, failed_ch);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R9: single-channel mode follows the home channel
    set_cfg(0, 0, 0, 0);
    rd(8'h01, "R9 home0"); rd(8'h02, "R9 home0");
    set_cfg(0, 0, 0, 1);
    rd(8'h03, "R9 home1"); wrt(8'h04, "R9 home1 write");
    idle("R10 idle");

    // R3: mirror enable without a valid mapping does nothing
    set_cfg(1, 0, 0, 1);
    rd(8'h05, "R3 no map"); rd(8'h06, "R3 no map");

    // R1/R2: first mirrored read on ch0, then alternation
    set_cfg(1, 0, 1, 1);
    rd(8'h10, "R1 first read ch0"); rd(8'h11, "R2 alt"); rd(8'h12, "R2 alt");
    wrt(8'h13, "R4 write both"); rd(8'h14, "R2 alt after write");
    rd(8'h15, "R2 alt");
    // R9: pointer frozen while mirrored mode is off
    set_cfg(1, 0, 0, 0);
    rd(8'h16, "R9 off"); rd(8'h17, "R9 off");
    set_cfg(1, 0, 1, 0);
    rd(8'h18, "R9 resume"); rd(8'h19, "R9 resume");

    // R8: lockstep wins over mirror; R11: reports ignored there
    set_cfg(1, 1, 1, 0);
    rd(8'h20, "R8 lockstep read"); wrt(8'h21, "R8 lockstep write");
    cyc(1, 0, 8'h22, 1, 1, 0, "R11 ue in lockstep");
    idle("R11 still intact");
    set_cfg(0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0, 0, "R11 ue in single mode");
    idle("R11 still intact");

    // R5: failure on ch1, same-cycle read uses the old state
    set_cfg(1, 0, 1, 0);
    cyc(1, 0, 8'h30, 1, 1, 0, "R5 ue ch1");
    rd(8'h31, "R7 read to ch0"); rd(8'h32, "R7 read to ch0");
    wrt(8'h33, "R7 write to ch0");
    cyc(1, 0, 8'h34, 1, 0, 0, "R5 second ue ignored");
    idle("R6 sticky"); idle("R6 sticky");
    set_cfg(0, 0, 0, 1);
    rd(8'h35, "R6 sticky off-mode"); 
    set_cfg(1, 1, 1, 1);
    rd(8'h36, "R8 lockstep over loss");
    set_cfg(1, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, "R6 clear");
    rd(8'h37, "R2 alt after clear"); rd(8'h38, "R2 alt after clear");
    cyc(0, 0, 0, 1, 0, 1, "R6 clear wins");
    cyc(0, 0, 0, 1, 0, 0, "R5 ue ch0");
    rd(8'h39, "R7 read to ch1"); wrt(8'h3A, "R7 write to ch1");
    cyc(0, 0, 0, 0, 0, 1, "R6 clear");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 25 == 0) set_cfg(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], lfsr[5] | lfsr[6], lfsr[7]);
      cyc(lfsr[8] | lfsr[9], lfsr[10] & lfsr[11], lfsr[7:0],
          lfsr[12] & lfsr[13] & lfsr[14], lfsr[15],
          (lfsr[3:0] == 4'h5), "R2 R7 R9 mixed");
    end
    idle("R10 drain"); idle("R10 drain");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule